// File: doc/BRIEF.md
# Hub Port Power Controller

This block governs the supply switches of the four downstream ports of a hub. For each port it drives one active-low enable toward an external power switch. It also watches one active-low over-current flag that comes back from that switch. The hub command logic sends it power requests and over-current clears. In return it reports a sticky over-current status vector and a one-clock change pulse.

Two static straps are captured once, on the first clock after reset is released. The first strap picks ganged switching, where every port shares one request and one fault. The other choice is per-port switching, where every port stands alone. The ganged choice only counts while the external-memory select is high: when that select is low, the shared strap pin carries serial data and the block falls back to per-port mode. The second strap marks whether the hub is bus-powered, and the block reports it unchanged.

Each over-current flag passes through a consecutive-clock filter, so a short spike never counts as a fault. A confirmed fault switches off the affected port, or every port in ganged mode. That port stays off until its status is cleared and a fresh rising power request arrives.

Top module: `hub_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, all four `pwr_on_n_o` bits are high, and `oc_status_o`, `oc_change_o`, `gang_mode_o` and `bus_pwr_mode_o` are all 0.
- R2: An over-current input that stays low for fewer than FILT_LEN consecutive clocks (default 16) sets no status bit and leaves the power outputs unchanged.
- R3: An over-current input that is low at FILT_LEN consecutive rising edges sets its status bit at the last of those edges. At that same edge the affected port turns off, so `pwr_on_n_o` for that port goes high. A port whose status bit is 1 is never powered.
- R4: In per-port mode, a fault on one port turns off only that port. The other ports keep their state.
- R5: In ganged mode, all four `pwr_on_n_o` bits are always equal and follow `gang_req_i`. Changes on `pwr_req_i` have no effect.
- R6: In ganged mode, a confirmed fault on any one input sets all four status bits and turns every port off.
- R7: A status bit stays set until it is cleared. In per-port mode, port i is cleared by `stat_clr_i[i]`. In ganged mode, `stat_clr_i[0]` clears all four bits. After a clear, the port stays off until its request goes low and then high again.
- R8: `oc_change_o` is high for exactly one clock, in the same cycle that any status bit goes from 0 to 1.
- R9: Ganged mode is entered only if `ext_mem_sel_i` and `gang_strap_i` are both 1 when they are captured on the first clock after reset. The captured mode, shown on `gang_mode_o`, ignores later strap changes.
- R10: Outside a fault, a port turns on one clock after its request rises, and turns off one clock after its request falls.
- R11: `bus_pwr_strap_i` is captured at the same moment as the other straps and shown on `bus_pwr_mode_o`. Later changes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_mem_sel_i | input | 1 | External-memory select strap; gang strap honoured only when high |
| gang_strap_i | input | 1 | Shared strap pin: 1 selects ganged switching |
| bus_pwr_strap_i | input | 1 | Bus-powered strap |
| pwr_req_i | input | 4 | Per-port power requests (level, 1 = on) |
| gang_req_i | input | 1 | Shared power request used in ganged mode |
| stat_clr_i | input | 4 | Status clear strobes |
| oc_n_i | input | 4 | Active-low over-current flags from the switches |
| pwr_on_n_o | output | 4 | Active-low port power enables |
| oc_status_o | output | 4 | Sticky over-current status, 1 = fault |
| oc_change_o | output | 1 | One-clock pulse when any status bit is set |
| gang_mode_o | output | 1 | Captured mode: 1 = ganged |
| bus_pwr_mode_o | output | 1 | Captured bus-powered strap |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that a clear strobe is the only way a status bit can fall, and that straps are driven to stable values before reset is released. The stimulus changes every input one time unit after a rising edge. It holds the straps steady through each reset and changes them only after capture, to show they are ignored. Over-current pulses are placed well away from clear strobes, so a clear and a new confirmation never happen in the same cycle.

// File: rtl/hub_pwr_pkg.sv
package hub_pwr_pkg;
  parameter int unsigned HUB_PORTS = 4;

  typedef logic [HUB_PORTS-1:0] port_vec_t;

  typedef struct packed {
    logic gang;
    logic bus_pwr;
  } strap_mode_t;

  function automatic port_vec_t fan_out(input logic bit_in);
    port_vec_t v;
    for (int i = 0; i < HUB_PORTS; i++) v[i] = bit_in;
    return v;
  endfunction
endpackage

// File: rtl/hub_pwr_rst_sync.sv
module hub_pwr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/hub_pwr_strap.sv
module hub_pwr_strap
  import hub_pwr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mem_sel,
  input  logic        gang_pin,
  input  logic        bus_pwr_pin,
  output strap_mode_t mode,
  output logic        cap_done
);
  strap_mode_t mode_q, mode_d;
  logic        done_q, done_d;

  always_comb begin
    mode_d = mode_q;
    done_d = done_q;
    if (!done_q) begin
      mode_d.gang    = ext_mem_sel & gang_pin;
      mode_d.bus_pwr = bus_pwr_pin;
      done_d         = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      done_q <= done_d;
    end
  end

  assign mode     = mode_q;
  assign cap_done = done_q;
endmodule

// File: rtl/hub_pwr_oc_filter.sv
module hub_pwr_oc_filter #(
  parameter int unsigned FILT_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic oc_n,
  output logic confirm
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] SAT  = CW'(FILT_LEN);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] run_q, run_d;
  logic          confirm_d;

  // Count consecutive low samples; saturate so one fault confirms once.
  always_comb begin
    run_d     = run_q;
    confirm_d = 1'b0;
    if (en) begin
      if (oc_n) begin
        run_d = '0;
      end else if (run_q != SAT) begin
        run_d     = run_q + 1'b1;
        confirm_d = (run_q == LAST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign confirm = confirm_d;
endmodule

// File: rtl/hub_pwr_switch.sv
module hub_pwr_switch
  import hub_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      gang,
  input  port_vec_t req,
  input  logic      gang_req,
  input  port_vec_t confirm,
  input  port_vec_t clr,
  output port_vec_t pwr_on,
  output port_vec_t status,
  output logic      change
);
  port_vec_t req_eff, conf_eff, clr_eff, rise;
  port_vec_t prev_q, prev_d;
  port_vec_t stat_q, stat_d;
  port_vec_t pwr_q, pwr_d;
  logic      chg_q, chg_d;

  always_comb begin
    req_eff  = gang ? fan_out(gang_req)  : req;
    conf_eff = gang ? fan_out(|confirm)  : confirm;
    clr_eff  = gang ? fan_out(clr[0])    : clr;
    rise     = req_eff & ~prev_q;

    prev_d = prev_q;
    stat_d = stat_q;
    pwr_d  = '0;
    if (en) begin
      prev_d = req_eff;
      stat_d = (stat_q & ~clr_eff) | conf_eff;
      pwr_d  = req_eff & ~stat_d & (pwr_q | rise);
    end
    chg_d = |(stat_d & ~stat_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
      pwr_q  <= '0;
      chg_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      stat_q <= stat_d;
      pwr_q  <= pwr_d;
      chg_q  <= chg_d;
    end
  end

  assign pwr_on = pwr_q;
  assign status = stat_q;
  assign change = chg_q;
endmodule

// File: rtl/hub_pwr_ctrl.sv
module hub_pwr_ctrl
  import hub_pwr_pkg::*;
#(
  parameter int unsigned FILT_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_mem_sel_i,
  input  logic       gang_strap_i,
  input  logic       bus_pwr_strap_i,
  input  logic [3:0] pwr_req_i,
  input  logic       gang_req_i,
  input  logic [3:0] stat_clr_i,
  input  logic [3:0] oc_n_i,
  output logic [3:0] pwr_on_n_o,
  output logic [3:0] oc_status_o,
  output logic       oc_change_o,
  output logic       gang_mode_o,
  output logic       bus_pwr_mode_o
);
  logic        rst_n_int;
  logic        cap_done;
  strap_mode_t mode;
  port_vec_t   confirm;
  port_vec_t   pwr_on;

  hub_pwr_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  hub_pwr_strap strap_i (
    .clk(clk), .rst_n(rst_n_int),
    .ext_mem_sel(ext_mem_sel_i), .gang_pin(gang_strap_i),
    .bus_pwr_pin(bus_pwr_strap_i),
    .mode(mode), .cap_done(cap_done)
  );

  for (genvar p = 0; p < HUB_PORTS; p++) begin : g_filt
    hub_pwr_oc_filter #(.FILT_LEN(FILT_LEN)) filt_i (
      .clk(clk), .rst_n(rst_n_int), .en(cap_done),
      .oc_n(oc_n_i[p]), .confirm(confirm[p])
    );
  end

  hub_pwr_switch sw_i (
    .clk(clk), .rst_n(rst_n_int), .en(cap_done), .gang(mode.gang),
    .req(pwr_req_i), .gang_req(gang_req_i), .confirm(confirm),
    .clr(stat_clr_i), .pwr_on(pwr_on), .status(oc_status_o),
    .change(oc_change_o)
  );

  assign pwr_on_n_o     = ~pwr_on;
  assign gang_mode_o    = mode.gang;
  assign bus_pwr_mode_o = mode.bus_pwr;
endmodule

// File: rtl/hub_pwr_ctrl_chk.sv
module hub_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cap_done,
  input logic [3:0] stat_clr_i,
  input logic [3:0] pwr_on_n_o,
  input logic [3:0] oc_status_o,
  input logic       oc_change_o,
  input logic       gang_mode_o,
  input logic       bus_pwr_mode_o
);
  assert_reset_off_R1: assert property (@(posedge clk)
    !rst_n |=> (pwr_on_n_o == 4'hF) && (oc_status_o == 4'h0) && !oc_change_o);

  assert_fault_unpowered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_status_o & ~pwr_on_n_o) == 4'h0);

  assert_gang_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gang_mode_o |-> ($countones(pwr_on_n_o) == 0 || $countones(pwr_on_n_o) == 4));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(oc_status_o) & ~oc_status_o) != 4'h0) |-> ($past(stat_clr_i) != 4'h0)));

  assert_change_on_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((oc_status_o & ~$past(oc_status_o)) != 4'h0) |-> oc_change_o);

  assert_change_only_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oc_change_o |-> ((oc_status_o & ~$past(oc_status_o)) != 4'h0));

  assert_strap_static_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_done) |-> $stable(gang_mode_o));

  assert_bus_strap_static_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_done) |-> $stable(bus_pwr_mode_o));
endmodule

bind hub_pwr_ctrl hub_pwr_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cap_done(cap_done), .stat_clr_i(stat_clr_i),
  .pwr_on_n_o(pwr_on_n_o), .oc_status_o(oc_status_o),
  .oc_change_o(oc_change_o), .gang_mode_o(gang_mode_o),
  .bus_pwr_mode_o(bus_pwr_mode_o)
);

// File: tb/hub_pwr_ctrl_tb_top.sv
module hub_pwr_ctrl_tb_top;
  localparam int FILT = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_mem_sel_i, gang_strap_i, bus_pwr_strap_i, gang_req_i;
  logic [3:0] pwr_req_i, stat_clr_i, oc_n_i;
  logic [3:0] pwr_on_n_o, oc_status_o;
  logic       oc_change_o, gang_mode_o, bus_pwr_mode_o;

  typedef struct {
    int         due;
    logic [3:0] pwr_n;
    logic [3:0] stat;
    logic       chg;
    logic       gang;
    logic       bus;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hub_pwr_ctrl #(.FILT_LEN(FILT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_mem_sel_i(ext_mem_sel_i),
    .gang_strap_i(gang_strap_i), .bus_pwr_strap_i(bus_pwr_strap_i),
    .pwr_req_i(pwr_req_i), .gang_req_i(gang_req_i), .stat_clr_i(stat_clr_i),
    .oc_n_i(oc_n_i), .pwr_on_n_o(pwr_on_n_o), .oc_status_o(oc_status_o),
    .oc_change_o(oc_change_o), .gang_mode_o(gang_mode_o),
    .bus_pwr_mode_o(bus_pwr_mode_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_at(input int d, input logic [3:0] pn, input logic [3:0] st,
                           input logic ch, input logic g, input logic b, input string tag);
    exp_t e;
    e.due = cyc + d; e.pwr_n = pn; e.stat = st; e.chg = ch;
    e.gang = g; e.bus = b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.due != cyc || pwr_on_n_o !== e.pwr_n || oc_status_o !== e.stat ||
          oc_change_o !== e.chg || gang_mode_o !== e.gang || bus_pwr_mode_o !== e.bus) begin
        fails++;
        $display("FAIL %s: actual pwr_n=%b stat=%b chg=%b gang=%b bus=%b expected pwr_n=%b stat=%b chg=%b gang=%b bus=%b",
                 e.tag, pwr_on_n_o, oc_status_o, oc_change_o, gang_mode_o, bus_pwr_mode_o,
                 e.pwr_n, e.stat, e.chg, e.gang, e.bus);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; ext_mem_sel_i = 1'b0; gang_strap_i = 1'b1; bus_pwr_strap_i = 1'b1;
    pwr_req_i = 4'h0; gang_req_i = 1'b0; stat_clr_i = 4'h0; oc_n_i = 4'hF;

    // Per-port mode: external memory selected low, so the gang strap is ignored.
    tick(3);
    expect_at(0, 4'hF, 4'h0, 0, 0, 0, "R1 reset state");
    tick(1);
    rst_n = 1'b1;
    tick(6);
    expect_at(0, 4'hF, 4'h0, 0, 0, 1, "R9 R11 per-port capture");
    bus_pwr_strap_i = 1'b0; ext_mem_sel_i = 1'b1;
    tick(3);
    expect_at(0, 4'hF, 4'h0, 0, 0, 1, "R9 R11 straps static");

    pwr_req_i = 4'hF;
    expect_at(1, 4'h0, 4'h0, 0, 0, 1, "R10 power on");
    tick(2);

    oc_n_i[1] = 1'b0;
    tick(FILT - 1);
    oc_n_i[1] = 1'b1;
    expect_at(2, 4'h0, 4'h0, 0, 0, 1, "R2 short spike ignored");
    tick(4);

    oc_n_i[2] = 1'b0;
    expect_at(FILT - 1, 4'h0, 4'h0, 0, 0, 1, "R2 before filter length");
    expect_at(FILT,     4'h4, 4'h4, 1, 0, 1, "R3 R4 R8 fault confirmed");
    expect_at(FILT + 1, 4'h4, 4'h4, 0, 0, 1, "R8 pulse one clock");
    tick(FILT + 1);
    oc_n_i[2] = 1'b1;
    tick(4);
    expect_at(0, 4'h4, 4'h4, 0, 0, 1, "R7 sticky status");

    stat_clr_i = 4'h4;
    expect_at(1, 4'h4, 4'h0, 0, 0, 1, "R7 cleared stays off");
    tick(1);
    stat_clr_i = 4'h0; pwr_req_i[2] = 1'b0;
    tick(1);
    pwr_req_i[2] = 1'b1;
    expect_at(1, 4'h0, 4'h0, 0, 0, 1, "R7 R10 fresh request");
    tick(2);
    pwr_req_i[0] = 1'b0;
    expect_at(1, 4'h1, 4'h0, 0, 0, 1, "R10 request off");
    tick(2);

    // Ganged mode.
    rst_n = 1'b0; pwr_req_i = 4'h0;
    ext_mem_sel_i = 1'b1; gang_strap_i = 1'b1; bus_pwr_strap_i = 1'b0;
    tick(2);
    expect_at(0, 4'hF, 4'h0, 0, 0, 0, "R1 reset again");
    tick(1);
    rst_n = 1'b1;
    tick(6);
    expect_at(0, 4'hF, 4'h0, 0, 1, 0, "R9 gang capture");
    gang_strap_i = 1'b0; ext_mem_sel_i = 1'b0; bus_pwr_strap_i = 1'b1;
    tick(3);
    expect_at(0, 4'hF, 4'h0, 0, 1, 0, "R9 R11 gang strap static");

    gang_req_i = 1'b1;
    expect_at(1, 4'h0, 4'h0, 0, 1, 0, "R5 gang on");
    tick(2);
    pwr_req_i = 4'hA;
    expect_at(1, 4'h0, 4'h0, 0, 1, 0, "R5 port requests ignored");
    tick(2);
    gang_req_i = 1'b0;
    expect_at(1, 4'hF, 4'h0, 0, 1, 0, "R5 gang off");
    tick(2);
    gang_req_i = 1'b1;
    expect_at(1, 4'h0, 4'h0, 0, 1, 0, "R5 gang on again");
    tick(2);

    oc_n_i[3] = 1'b0;
    expect_at(FILT - 1, 4'h0, 4'h0, 0, 1, 0, "R2 gang before filter length");
    expect_at(FILT,     4'hF, 4'hF, 1, 1, 0, "R6 R8 gang fault");
    expect_at(FILT + 1, 4'hF, 4'hF, 0, 1, 0, "R8 gang pulse end");
    tick(FILT + 1);
    oc_n_i[3] = 1'b1;
    tick(3);
    stat_clr_i = 4'h1;
    expect_at(1, 4'hF, 4'h0, 0, 1, 0, "R7 gang clear");
    tick(1);
    stat_clr_i = 4'h0; gang_req_i = 1'b0;
    tick(1);
    gang_req_i = 1'b1;
    expect_at(1, 4'h0, 4'h0, 0, 1, 0, "R7 gang fresh request");
    tick(3);

    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    done = 1'b1;
    summary();
  end
endmodule